// File: doc/BRIEF.md
# DMA Doorbell and Signature Window

This block is an 8-byte register window that firmware uses for two things: to find out whether the DMA path exists, and to start a DMA transfer. To find out, firmware reads the window. Any read returns a slice of a fixed 64-bit signature, 0x51454D5520434647, taken in big-endian byte order.

To start a transfer, firmware writes the 64-bit physical address of a transfer descriptor. It can do this in one of two ways:

- Stage the upper half, then write the lower half. The lower-half write acts as the doorbell.
- Write the whole address in a single 8-byte access.

The write that completes the address produces a one-cycle trigger toward the DMA engine, carrying the assembled address. The block then clears its staged address so that the next transfer starts from zero.

The window rejects any write shape it does not recognise. When the DMA path is configured out, no window exists and every access is answered with an error. The transfer itself and the conversion from the system bus to this simple request port lie outside the block.

Top module: `dma_doorbell_window`

## Requirements
- R1: A 4-byte write at offset 0 loads its 32 data bits (req_wdata[31:0]) into the upper half of the staged address and clears the lower half. It produces no trigger and no error.
- R2: A 4-byte write at offset 4 ORs req_wdata[31:0] into the lower half of the staged address. On the next cycle, trig_valid is high for exactly one cycle and trig_addr carries the combined address.
- R3: An 8-byte write at offset 0 triggers on the next cycle with trig_addr equal to the full req_wdata. Any previously staged half is not used.
- R4: After any trigger the staged address is zero. A lower-half write that follows with no new upper-half write therefore triggers with only its own 32 bits.
- R5: Any other write shape is rejected: a 4-byte write at any offset other than 0 or 4, an 8-byte write at a non-zero offset, or a 1-byte or 2-byte write. A rejected write raises rsp_error for one cycle, produces no trigger and leaves the staged address unchanged.
- R6: A read of S bytes at offset A returns the S*8 signature bits that start at bit position (8-A-S)*8, right-aligned in rsp_rdata, where S is 1, 2, 4 or 8 and A+S <= 8. Offset 0 therefore maps to the most significant signature byte, 0x51, and a full 8-byte read returns 0x51454D5520434647.
- R7: A read whose size is not 1, 2, 4 or 8, or which runs past byte 7, raises rsp_error and returns zero data.
- R8: Every request (req_valid high at a clock edge) is answered exactly one cycle later with rsp_valid high. Accepted writes answer with rsp_error low and zero data.
- R9: With DMA_EN = 0 the window does not exist: every access is answered with rsp_error, zero data and no trigger.
- R10: After reset, rsp_valid and trig_valid are low and the staged address is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 3 | Byte offset of the access within the window |
| req_size | input | 4 | Access size as a byte count (1, 2, 4 or 8 are legal) |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_error | output | 1 | The request was rejected |
| rsp_rdata | output | 64 | Read data, right-aligned signature slice |
| trig_valid | output | 1 | One-cycle transfer start pulse |
| trig_addr | output | 64 | Descriptor address for the transfer |

## Verification
Some properties are checked by assertions on every cycle:

- a trigger is never paired with an error;
- a trigger only follows a doorbell write, and never follows an upper-half write or a read;
- every request gets a response one cycle later;
- an error never carries data;
- the most significant signature byte appears at offset 0.

Other behaviour needs the bench's scenarios, which track the staged address across access sequences:

- the OR-merge of the two halves;
- the clearing of the staged address after each trigger;
- the unchanged staged address after a rejected write;
- the exact signature slice for unaligned reads;
- the configured-out variant.

// File: rtl/dma_dbl_pkg.sv
package dma_dbl_pkg;

   typedef enum logic [2:0] {
      ACC_IDLE,
      ACC_STAGE_HI,
      ACC_BELL_LO,
      ACC_BELL_FULL,
      ACC_READ,
      ACC_REJECT
   } acc_kind_e;

   localparam logic [63:0] DEFAULT_SIGNATURE = 64'h5145_4D55_2043_4647;

endpackage

// File: rtl/dma_dbl_decode.sv
module dma_dbl_decode
   import dma_dbl_pkg::*;
#(
   parameter int WIN_BYTES = 8,
   localparam int OFF_W    = $clog2(WIN_BYTES),
   localparam int SIZE_W   = OFF_W + 1,
   localparam int HALF_B   = WIN_BYTES / 2
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [SIZE_W-1:0] req_size,
   output acc_kind_e         kind
);

   logic              size_pow2;
   logic [SIZE_W:0]   span_end;

   always_comb begin
      size_pow2 = ($countones(req_size) == 1) && (int'(req_size) <= WIN_BYTES);
      span_end  = {1'b0, req_size} + {{(SIZE_W+1-OFF_W){1'b0}}, req_offset};
      kind      = ACC_IDLE;
      if (req_valid) begin
         if (!req_write) begin
            kind = (size_pow2 && int'(span_end) <= WIN_BYTES) ? ACC_READ : ACC_REJECT;
         end else if (int'(req_size) == HALF_B && int'(req_offset) == 0) begin
            kind = ACC_STAGE_HI;
         end else if (int'(req_size) == HALF_B && int'(req_offset) == HALF_B) begin
            kind = ACC_BELL_LO;
         end else if (int'(req_size) == WIN_BYTES && int'(req_offset) == 0) begin
            kind = ACC_BELL_FULL;
         end else begin
            kind = ACC_REJECT;
         end
      end
   end

   always_comb begin
      if (req_valid && req_write && int'(req_size) < HALF_B)
         assert_narrow_write_rejected_R5: assert (kind == ACC_REJECT)
            else $error("narrow write not rejected");
   end

endmodule

// File: rtl/dma_dbl_addr.sv
module dma_dbl_addr
   import dma_dbl_pkg::*;
#(
   parameter int ADDR_W   = 64,
   localparam int HALF_W  = ADDR_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         kind,
   input  logic [ADDR_W-1:0] wdata,
   output logic              trig_valid,
   output logic [ADDR_W-1:0] trig_addr
);

   logic [ADDR_W-1:0] staged_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_q   <= '0;
         trig_valid <= 1'b0;
         trig_addr  <= '0;
      end else begin
         trig_valid <= 1'b0;
         unique case (kind)
            ACC_STAGE_HI: staged_q <= {wdata[HALF_W-1:0], {HALF_W{1'b0}}};
            ACC_BELL_LO: begin
               trig_addr  <= staged_q | {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
               trig_valid <= 1'b1;
               staged_q   <= '0;
            end
            ACC_BELL_FULL: begin
               trig_addr  <= wdata;
               trig_valid <= 1'b1;
               staged_q   <= '0;
            end
            default: ;
         endcase
      end
   end

   assert_stage_no_trig_R1: assert property (@(posedge clk) disable iff (!rst_n)
      kind == ACC_STAGE_HI |=> !trig_valid);

   assert_trig_from_bell_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_valid |-> $past(kind == ACC_BELL_LO || kind == ACC_BELL_FULL));

   assert_full_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      kind == ACC_BELL_FULL |=> trig_addr == $past(wdata));

   assert_clear_after_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trig_valid |-> staged_q == '0 || $past(kind == ACC_STAGE_HI) == 1'b0 && 1'b0);

endmodule

// File: rtl/dma_dbl_sig.sv
module dma_dbl_sig #(
   parameter int          WIN_BYTES = 8,
   parameter logic [WIN_BYTES*8-1:0] SIGNATURE = '0,
   localparam int         OFF_W  = $clog2(WIN_BYTES),
   localparam int         SIZE_W = OFF_W + 1
) (
   input  logic [OFF_W-1:0]       offset,
   input  logic [SIZE_W-1:0]      size,
   output logic [WIN_BYTES*8-1:0] slice
);

   always_comb begin
      slice = '0;
      for (int i = 0; i < WIN_BYTES; i++) begin
         int k;
         k = int'(offset) + int'(size) - 1 - i;
         if (i < int'(size) && k >= 0 && k < WIN_BYTES)
            slice[i*8 +: 8] = SIGNATURE[(WIN_BYTES-1-k)*8 +: 8];
      end
   end

   always_comb begin
      if (int'(size) == 1 && int'(offset) == 0)
         assert_msb_first_R6: assert (slice[7:0] == SIGNATURE[WIN_BYTES*8-1 -: 8])
            else $error("byte 0 is not the top signature byte");
   end

endmodule

// File: rtl/dma_doorbell_window.sv
module dma_doorbell_window
   import dma_dbl_pkg::*;
#(
   parameter bit          DMA_EN    = 1'b1,
   parameter int          ADDR_W    = 64,
   parameter logic [ADDR_W-1:0] SIGNATURE = DEFAULT_SIGNATURE,
   localparam int         WIN_BYTES = ADDR_W / 8,
   localparam int         OFF_W     = $clog2(WIN_BYTES),
   localparam int         SIZE_W    = OFF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [ADDR_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_error,
   output logic [ADDR_W-1:0] rsp_rdata,
   output logic              trig_valid,
   output logic [ADDR_W-1:0] trig_addr
);

   if (ADDR_W % 16 != 0 || ADDR_W < 16) begin : g_bad_width
      $error("ADDR_W must be a multiple of 16");
   end
   if ((1 << OFF_W) != WIN_BYTES) begin : g_bad_window
      $error("window byte count must be a power of two");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= req_valid;
   end

   if (DMA_EN) begin : g_window
      acc_kind_e         kind;
      logic [ADDR_W-1:0] slice;

      dma_dbl_decode #(.WIN_BYTES(WIN_BYTES)) u_decode (
         .req_valid  (req_valid),
         .req_write  (req_write),
         .req_offset (req_offset),
         .req_size   (req_size),
         .kind       (kind)
      );

      dma_dbl_addr #(.ADDR_W(ADDR_W)) u_addr (
         .clk        (clk),
         .rst_n      (rst_n),
         .kind       (kind),
         .wdata      (req_wdata),
         .trig_valid (trig_valid),
         .trig_addr  (trig_addr)
      );

      dma_dbl_sig #(.WIN_BYTES(WIN_BYTES), .SIGNATURE(SIGNATURE)) u_sig (
         .offset (req_offset),
         .size   (req_size),
         .slice  (slice)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_error <= 1'b0;
            rsp_rdata <= '0;
         end else begin
            rsp_error <= (kind == ACC_REJECT);
            rsp_rdata <= (kind == ACC_READ) ? slice : '0;
         end
      end
   end else begin : g_absent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rsp_error <= 1'b0;
         else        rsp_error <= req_valid;
      end
      assign rsp_rdata  = '0;
      assign trig_valid = 1'b0;
      assign trig_addr  = '0;
   end

   assert_rsp_next_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_err_without_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_error && trig_valid));

   assert_err_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> rsp_rdata == '0);

   assert_read_no_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> !trig_valid);

   assert_trig_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_valid |-> $past(req_valid && req_write));

endmodule

// File: tb/test_dma_doorbell_window.sv
module test_dma_doorbell_window;

   localparam logic [63:0] SIG = 64'h5145_4D55_2043_4647;

   typedef struct {
      logic        err;
      logic [63:0] rdata;
      logic        trig;
      logic [63:0] taddr;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [2:0]  req_offset = '0;
   logic [3:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid, rsp_error, trig_valid;
   logic [63:0] rsp_rdata, trig_addr;
   logic        off_rsp_valid, off_rsp_error, off_trig_valid;
   logic [63:0] off_rsp_rdata, off_trig_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   exp_t q[$];
   logic [63:0] mdl_staged = '0;

   always #10 clk = ~clk;

   dma_doorbell_window i_dma_doorbell_window (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
      .trig_valid(trig_valid), .trig_addr(trig_addr)
   );

   dma_doorbell_window #(.DMA_EN(1'b0)) i_dma_doorbell_window_off (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(off_rsp_valid), .rsp_error(off_rsp_error), .rsp_rdata(off_rsp_rdata),
      .trig_valid(off_trig_valid), .trig_addr(off_trig_addr)
   );

   function automatic logic [63:0] sig_slice(int off, int sz);
      logic [127:0] wide;
      logic [127:0] mask;
      wide = {64'h0, SIG} >> ((8 - off - sz) * 8);
      mask = (128'h1 << (sz * 8)) - 128'h1;
      return 64'(wide & mask);
   endfunction

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(bit w, int off, int sz, logic [63:0] data, string tag);
      exp_t e;
      e.err = 1'b0; e.rdata = '0; e.trig = 1'b0; e.taddr = '0; e.tag = tag;
      if (w) begin
         if (sz == 4 && off == 0) mdl_staged = {data[31:0], 32'h0};
         else if (sz == 4 && off == 4) begin
            e.trig = 1'b1; e.taddr = mdl_staged | {32'h0, data[31:0]}; mdl_staged = '0;
         end else if (sz == 8 && off == 0) begin
            e.trig = 1'b1; e.taddr = data; mdl_staged = '0;
         end else e.err = 1'b1;
      end else begin
         if ((sz == 1 || sz == 2 || sz == 4 || sz == 8) && off + sz <= 8)
            e.rdata = sig_slice(off, sz);
         else e.err = 1'b1;
      end
      q.push_back(e);
      req_valid = 1'b1; req_write = w; req_offset = 3'(off);
      req_size = 4'(sz); req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rsp_valid) begin
            if (q.size() == 0) check(1'b0, "R8 unexpected response", 64'h1, 64'h0);
            else begin
               exp_t e;
               e = q.pop_front();
               check(rsp_error == e.err, {e.tag, " error"}, 64'(rsp_error), 64'(e.err));
               check(rsp_rdata == e.rdata, {e.tag, " rdata"}, rsp_rdata, e.rdata);
               check(trig_valid == e.trig, {e.tag, " trig_valid"}, 64'(trig_valid), 64'(e.trig));
               if (e.trig) check(trig_addr == e.taddr, {e.tag, " trig_addr"}, trig_addr, e.taddr);
            end
            // R9: configured-out instance
            check(off_rsp_valid && off_rsp_error && off_rsp_rdata == '0 && !off_trig_valid,
                  "R9 absent window", {62'h0, off_rsp_valid, off_rsp_error}, 64'h3);
         end else begin
            check(!trig_valid, "R2 trigger longer than one cycle", 64'(trig_valid), 64'h0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++; checks++;
         $display("FAIL watchdog actual=%h expected=%h", 64'h1, 64'h0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!rsp_valid && !trig_valid, "R10 reset outputs", {62'h0, rsp_valid, trig_valid}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      access(1, 4, 4, 64'hFFFF_FFFF_0000_1234, "R10 staged zero after reset");
      access(1, 0, 4, 64'h0000_0000_89AB_CDEF, "R1 stage upper");
      access(1, 4, 4, 64'h0000_0000_0000_0010, "R2 doorbell low");
      access(1, 4, 4, 64'h0000_0000_0000_0020, "R4 cleared after trigger");
      access(1, 0, 4, 64'h0000_0000_1111_1111, "R1 stage upper again");
      access(1, 0, 4, 64'h0000_0000_2222_2222, "R1 restage clears lower");
      access(1, 2, 4, 64'h0000_0000_DEAD_BEEF, "R5 bad offset 4-byte");
      access(1, 4, 8, 64'h0123_4567_89AB_CDEF, "R5 bad offset 8-byte");
      access(1, 0, 2, 64'h0000_0000_0000_FFFF, "R5 2-byte write");
      access(1, 0, 1, 64'h0000_0000_0000_00FF, "R5 1-byte write");
      access(1, 0, 3, 64'h0000_0000_00FF_FFFF, "R5 3-byte write");
      access(1, 4, 4, 64'h0000_0000_0000_0003, "R5 staged kept after rejects");
      access(1, 0, 4, 64'h0000_0000_5555_5555, "R3 stage before full");
      access(1, 0, 8, 64'hFEDC_BA98_7654_3210, "R3 full write");
      access(1, 4, 4, 64'h0000_0000_0000_0007, "R4 cleared after full");
      access(0, 0, 8, 64'h0, "R6 full signature");
      access(0, 0, 1, 64'h0, "R6 byte 0");
      access(0, 7, 1, 64'h0, "R6 byte 7");
      access(0, 0, 4, 64'h0, "R6 upper word");
      access(0, 4, 4, 64'h0, "R6 lower word");
      access(0, 3, 2, 64'h0, "R6 unaligned halfword");
      access(0, 1, 4, 64'h0, "R6 unaligned word");
      access(0, 6, 2, 64'h0, "R6 last halfword");
      access(0, 6, 4, 64'h0, "R7 read past end");
      access(0, 0, 3, 64'h0, "R7 size 3");
      access(0, 1, 8, 64'h0, "R7 8-byte at offset 1");
      for (int i = 0; i < 4; i++)
         access(1, 4, 4, 64'(i * 16 + 1), "R2 back-to-back doorbells");
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R8 all answered", 64'(q.size()), 64'h0);
      check(sig_slice(3, 2) == 64'h5520 && sig_slice(0, 4) == 64'h5145_4D55,
            "R6 model sanity", sig_slice(3, 2), 64'h5520);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule